// File: doc/BRIEF.md
# CCD Field Readout Timing Generator

This block produces the logic-level timing for an interline CCD that is read out one field at a time. It has a pixel counter that spans one sensor line, including the horizontal dummy bits. It also has a line counter that spans one field, including vertical blanking. From these two counters it decodes region flags. Each pixel position is marked as dummy, optical black or effective. Each line is marked as blanking, vertical dummy, optical black or effective. Downstream clamp logic uses the optical-black flags, and the processing pipeline uses the effective-image strobe.

The block keeps an odd/even field flag. Even fields carry one extra vertical dummy line ahead of the sensor rows. Once per field, during vertical blanking, it opens a sensor-readout pulse window. On a programmable range of lines after the readout, it opens an electronic-shutter drain window at the start of the line, which shortens the charge-storage time. Both pulse widths are measured in ticks of an external timing tick rather than in pixel clocks. The shutter setting is captured only at the field boundary.

Top module: `ccd_readout_timing_gen`

## Requirements
- R1: `pix_count` counts 0 to H_TOTAL-1 (H_TOTAL = H_DUMMY + H_OB_FRONT + H_EFFECTIVE + H_OB_REAR, 553 by default) and then returns to 0. `line_count` advances by one on each return to 0.
- R2: On every line exactly one horizontal flag is high. `h_dummy` covers the first H_DUMMY (16) positions. `h_optblack` covers the next H_OB_FRONT (2) positions and the last H_OB_REAR (25) positions. `h_effective` covers the H_EFFECTIVE (510) positions between the two optical-black runs.
- R3: Lines 0 to V_BLANK-1 assert `v_blank`. In even fields, line V_BLANK asserts `v_dummy`. The sensor rows follow: V_OB_FRONT (12) lines with `v_optblack`, then V_EFFECTIVE (492) lines with `v_effective`, then V_OB_REAR (1) line with `v_optblack`.
- R4: An odd field lasts V_BLANK+505 lines and an even field lasts one line more. At the end of the last pixel of a field, `line_count` returns to 0 and `field_odd` inverts. The first field after reset is odd (`field_odd`=1).
- R5: `image_valid` is high exactly when both `h_effective` and `v_effective` are high. That gives H_EFFECTIVE×V_EFFECTIVE cycles per field.
- R6: `readout_pulse` rises once per field, one clock after pixel 0 of line READ_LINE. It stays high until it has seen READ_TICKS cycles with `time_tick` high, and falls on the clock after the last of them.
- R7: `drain_pulse` starts one clock after pixel 0 of every line L with READ_LINE < L < the held shutter value. Each drain lasts DRAIN_TICKS ticks, counted the same way as in R6. A held value of READ_LINE+1 or less gives no drain in that field.
- R8: `shutter_line` is captured into `shutter_hold` only on the clock that ends a field, and it governs the following field. Changes in the middle of a field have no effect on the current field. After reset the held value is 0.
- R9: While reset is asserted, both counters are 0, `field_odd` is 1, both pulses are low, and the flags show a dummy pixel on a blanking line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_tick | input | 1 | Timing tick used to measure pulse widths |
| shutter_line | input | V_W | First line with no drain (storage start), captured at field end |
| pix_count | output | H_W | Pixel position within the line |
| line_count | output | V_W | Line position within the field |
| field_odd | output | 1 | High during odd fields |
| shutter_hold | output | V_W | Shutter value in force for this field |
| h_dummy | output | 1 | Horizontal dummy bit |
| h_optblack | output | 1 | Horizontal optical-black pixel (front or rear) |
| h_effective | output | 1 | Horizontal effective pixel |
| v_blank | output | 1 | Vertical blanking line |
| v_dummy | output | 1 | Vertical dummy line (even fields only) |
| v_optblack | output | 1 | Vertical optical-black line (front or rear) |
| v_effective | output | 1 | Vertical effective line |
| image_valid | output | 1 | Effective pixel on an effective line |
| readout_pulse | output | 1 | Sensor readout pulse window |
| drain_pulse | output | 1 | Electronic-shutter drain pulse window |

## Verification
The bench runs whole fields of both parities with a reduced geometry. It compares every cycle's counters and flags with its own model and tallies flag totals per field. This separates a fault in the ordering of the horizontal regions from a fault in the vertical regions, and it catches a dummy line that appears in the wrong parity. The tick is asserted every cycle, every second cycle and every third cycle, so a pulse that is timed in clocks instead of ticks stands out. The shutter value is stepped through 6, 3, 2, 15 and 0, each changed in the middle of a field. This covers a drain range inside the field, a single drain line, the empty boundary case and a range clipped by the field end. It also shows that a mid-field change waits for the boundary. A reset in the middle of a field confirms the restart state.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    typedef enum logic [1:0] {
        HZ_DUMMY,
        HZ_OB_LEAD,
        HZ_ACTIVE,
        HZ_OB_TRAIL
    } hzone_e;

    typedef enum logic [2:0] {
        VZ_BLANK,
        VZ_DUMMY,
        VZ_OB_LEAD,
        VZ_ACTIVE,
        VZ_OB_TRAIL
    } vzone_e;

endpackage

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_tg_pkg::*;
#(
    parameter int H_DUMMY     = 16,
    parameter int H_OB_FRONT  = 2,
    parameter int H_EFFECTIVE = 510,
    parameter int H_OB_REAR   = 25,
    localparam int H_TOTAL    = H_DUMMY + H_OB_FRONT + H_EFFECTIVE + H_OB_REAR,
    localparam int H_W        = $clog2(H_TOTAL)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [H_W-1:0] pix_count,
    output logic           line_start,
    output logic           line_end,
    output hzone_e         hzone
);

    localparam logic [H_W-1:0] LAST_PIX  = H_W'(H_TOTAL - 1);
    localparam logic [H_W-1:0] EDGE_OBF  = H_W'(H_DUMMY);
    localparam logic [H_W-1:0] EDGE_ACT  = H_W'(H_DUMMY + H_OB_FRONT);
    localparam logic [H_W-1:0] EDGE_OBR  = H_W'(H_DUMMY + H_OB_FRONT + H_EFFECTIVE);

    typedef struct packed {
        logic [H_W-1:0] pix;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pix == LAST_PIX) begin
            st_d.pix = '0;
        end else begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.pix < EDGE_OBF) begin
            hzone = HZ_DUMMY;
        end else if (st_q.pix < EDGE_ACT) begin
            hzone = HZ_OB_LEAD;
        end else if (st_q.pix < EDGE_OBR) begin
            hzone = HZ_ACTIVE;
        end else begin
            hzone = HZ_OB_TRAIL;
        end
    end

    assign pix_count  = st_q.pix;
    assign line_start = (st_q.pix == '0);
    assign line_end   = (st_q.pix == LAST_PIX);

    // R1: the last pixel position is followed by position 0
    a_r1_pixel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_count == LAST_PIX) |=> (pix_count == '0));

    // R1: any other position is followed by the next one
    a_r1_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_count != LAST_PIX) |=> (pix_count == H_W'($past(pix_count) + 1'b1)));

endmodule

// File: rtl/ccd_field_timer.sv
module ccd_field_timer
    import ccd_tg_pkg::*;
#(
    parameter int V_BLANK     = 20,
    parameter int V_OB_FRONT  = 12,
    parameter int V_EFFECTIVE = 492,
    parameter int V_OB_REAR   = 1,
    localparam int V_ROWS     = V_OB_FRONT + V_EFFECTIVE + V_OB_REAR,
    localparam int V_W        = $clog2(V_BLANK + V_ROWS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_end,
    input  logic [V_W-1:0] shutter_line,
    output logic [V_W-1:0] line_count,
    output logic           field_odd,
    output logic [V_W-1:0] shutter_hold,
    output logic           field_end,
    output vzone_e         vzone
);

    localparam logic [V_W-1:0] ODD_LAST  = V_W'(V_BLANK + V_ROWS - 1);
    localparam logic [V_W-1:0] EVEN_LAST = V_W'(V_BLANK + V_ROWS);

    typedef struct packed {
        logic [V_W-1:0] line;
        logic           odd;
        logic [V_W-1:0] shut;
    } field_state_t;

    field_state_t st_d, st_q;
    logic [V_W-1:0] last_line;
    int             row;

    always_comb begin
        last_line = st_q.odd ? ODD_LAST : EVEN_LAST;
        field_end = line_end && (st_q.line == last_line);
        st_d      = st_q;
        if (field_end) begin
            st_d.line = '0;
            st_d.odd  = ~st_q.odd;
            st_d.shut = shutter_line;
        end else if (line_end) begin
            st_d.line = st_q.line + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line <= '0;
            st_q.odd  <= 1'b1;
            st_q.shut <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        row = int'(st_q.line) - V_BLANK - (st_q.odd ? 0 : 1);
        if (int'(st_q.line) < V_BLANK) begin
            vzone = VZ_BLANK;
        end else if (!st_q.odd && (int'(st_q.line) == V_BLANK)) begin
            vzone = VZ_DUMMY;
        end else if (row < V_OB_FRONT) begin
            vzone = VZ_OB_LEAD;
        end else if (row < V_OB_FRONT + V_EFFECTIVE) begin
            vzone = VZ_ACTIVE;
        end else begin
            vzone = VZ_OB_TRAIL;
        end
    end

    assign line_count   = st_q.line;
    assign field_odd    = st_q.odd;
    assign shutter_hold = st_q.shut;

    // R4: a field boundary restarts the line count and flips parity
    a_r4_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
        field_end |=> ((line_count == '0) && (field_odd != $past(field_odd))));

    // R4: odd fields never reach the extra even-field line
    a_r4_odd_length: assert property (@(posedge clk) disable iff (!rst_n)
        field_odd |-> (line_count <= ODD_LAST));

    // R8: the held shutter value moves only at a field boundary
    a_r8_shutter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !field_end |=> $stable(shutter_hold));

endmodule

// File: rtl/ccd_strobe_gen.sv
module ccd_strobe_gen #(
    parameter int TICKS = 5,
    localparam int CW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic pulse
);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] left;
    } strobe_state_t;

    strobe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.on   = 1'b1;
            st_d.left = CW'(TICKS);
        end else if (st_q.on && tick) begin
            if (st_q.left == CW'(1)) begin
                st_d.on   = 1'b0;
                st_d.left = '0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.on;

    // R6/R7: a start request opens the window on the next clock
    a_r6_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pulse);

    // R6/R7: without a tick an open window cannot close
    a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !tick && !start) |=> pulse);

    // R6/R7: a closed window stays closed without a start
    a_r6_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse && !start) |=> !pulse);

endmodule

// File: rtl/ccd_readout_timing_gen.sv
module ccd_readout_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int H_DUMMY     = 16,
    parameter int H_OB_FRONT  = 2,
    parameter int H_EFFECTIVE = 510,
    parameter int H_OB_REAR   = 25,
    parameter int V_BLANK     = 20,
    parameter int V_OB_FRONT  = 12,
    parameter int V_EFFECTIVE = 492,
    parameter int V_OB_REAR   = 1,
    parameter int READ_LINE   = 10,
    parameter int READ_TICKS  = 5,
    parameter int DRAIN_TICKS = 4,
    localparam int H_TOTAL    = H_DUMMY + H_OB_FRONT + H_EFFECTIVE + H_OB_REAR,
    localparam int V_ROWS     = V_OB_FRONT + V_EFFECTIVE + V_OB_REAR,
    localparam int H_W        = $clog2(H_TOTAL),
    localparam int V_W        = $clog2(V_BLANK + V_ROWS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           time_tick,
    input  logic [V_W-1:0] shutter_line,
    output logic [H_W-1:0] pix_count,
    output logic [V_W-1:0] line_count,
    output logic           field_odd,
    output logic [V_W-1:0] shutter_hold,
    output logic           h_dummy,
    output logic           h_optblack,
    output logic           h_effective,
    output logic           v_blank,
    output logic           v_dummy,
    output logic           v_optblack,
    output logic           v_effective,
    output logic           image_valid,
    output logic           readout_pulse,
    output logic           drain_pulse
);

    localparam logic [V_W-1:0] READ_AT = V_W'(READ_LINE);

    logic   line_start, line_end, field_end;
    hzone_e hzone;
    vzone_e vzone;
    logic   read_start, drain_start;

    ccd_line_timer #(
        .H_DUMMY    (H_DUMMY),
        .H_OB_FRONT (H_OB_FRONT),
        .H_EFFECTIVE(H_EFFECTIVE),
        .H_OB_REAR  (H_OB_REAR)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_count (pix_count),
        .line_start(line_start),
        .line_end  (line_end),
        .hzone     (hzone)
    );

    ccd_field_timer #(
        .V_BLANK    (V_BLANK),
        .V_OB_FRONT (V_OB_FRONT),
        .V_EFFECTIVE(V_EFFECTIVE),
        .V_OB_REAR  (V_OB_REAR)
    ) u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_end    (line_end),
        .shutter_line(shutter_line),
        .line_count  (line_count),
        .field_odd   (field_odd),
        .shutter_hold(shutter_hold),
        .field_end   (field_end),
        .vzone       (vzone)
    );

    always_comb begin
        read_start  = line_start && (line_count == READ_AT);
        drain_start = line_start && (line_count > READ_AT) && (line_count < shutter_hold);
    end

    ccd_strobe_gen #(.TICKS(READ_TICKS)) u_read (
        .clk  (clk),
        .rst_n(rst_n),
        .start(read_start),
        .tick (time_tick),
        .pulse(readout_pulse)
    );

    ccd_strobe_gen #(.TICKS(DRAIN_TICKS)) u_drain (
        .clk  (clk),
        .rst_n(rst_n),
        .start(drain_start),
        .tick (time_tick),
        .pulse(drain_pulse)
    );

    always_comb begin
        h_dummy     = (hzone == HZ_DUMMY);
        h_optblack  = (hzone == HZ_OB_LEAD) || (hzone == HZ_OB_TRAIL);
        h_effective = (hzone == HZ_ACTIVE);
        v_blank     = (vzone == VZ_BLANK);
        v_dummy     = (vzone == VZ_DUMMY);
        v_optblack  = (vzone == VZ_OB_LEAD) || (vzone == VZ_OB_TRAIL);
        v_effective = (vzone == VZ_ACTIVE);
        image_valid = h_effective && v_effective;
    end

    // R6: the readout window opens just after pixel 0 of the readout line
    a_r6_read_place: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(readout_pulse) |-> ((line_count == READ_AT) && (pix_count == H_W'(1))));

    // R7: a drain window opens only inside the held shutter range
    a_r7_drain_place: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drain_pulse) |-> ((line_count > READ_AT) && (line_count < shutter_hold)
                                && (pix_count == H_W'(1))));

    // R3: the dummy line never appears in an odd field
    a_r3_dummy_even: assert property (@(posedge clk) disable iff (!rst_n)
        v_dummy |-> !field_odd);

endmodule

// File: tb/ccd_readout_timing_gen_test.sv
module ccd_readout_timing_gen_test;

    localparam int HD = 3, HF = 2, HE = 6, HR = 3;
    localparam int VB = 4, VF = 2, VE = 4, VR = 1;
    localparam int RL = 1, RT = 5, DT = 4;
    localparam int HT = HD + HF + HE + HR;
    localparam int ROWS = VF + VE + VR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       time_tick = 1'b0;
    logic [3:0] shutter_line = 4'd0;
    logic [3:0] pix_count;
    logic [3:0] line_count;
    logic [3:0] shutter_hold;
    logic       field_odd, h_dummy, h_optblack, h_effective;
    logic       v_blank, v_dummy, v_optblack, v_effective, image_valid;
    logic       readout_pulse, drain_pulse;

    int checks = 0;
    int failures = 0;
    int eh = 0, ev = 0, eshut = 0;
    bit eodd = 1'b1;

    always #2 clk = ~clk;

    ccd_readout_timing_gen #(
        .H_DUMMY(HD), .H_OB_FRONT(HF), .H_EFFECTIVE(HE), .H_OB_REAR(HR),
        .V_BLANK(VB), .V_OB_FRONT(VF), .V_EFFECTIVE(VE), .V_OB_REAR(VR),
        .READ_LINE(RL), .READ_TICKS(RT), .DRAIN_TICKS(DT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .time_tick(time_tick), .shutter_line(shutter_line),
        .pix_count(pix_count), .line_count(line_count), .field_odd(field_odd),
        .shutter_hold(shutter_hold), .h_dummy(h_dummy), .h_optblack(h_optblack),
        .h_effective(h_effective), .v_blank(v_blank), .v_dummy(v_dummy),
        .v_optblack(v_optblack), .v_effective(v_effective), .image_valid(image_valid),
        .readout_pulse(readout_pulse), .drain_pulse(drain_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk(pix_count == 0, "R9", {tag, " pix_count"}, int'(pix_count), 0);
        chk(line_count == 0, "R9", {tag, " line_count"}, int'(line_count), 0);
        chk(field_odd == 1'b1, "R9", {tag, " field_odd"}, int'(field_odd), 1);
        chk(!readout_pulse && !drain_pulse, "R9", {tag, " pulses"},
            int'({readout_pulse, drain_pulse}), 0);
        chk(h_dummy && v_blank, "R9", {tag, " dummy pixel on blank line"},
            int'({h_dummy, v_blank}), 3);
        chk(shutter_hold == 0, "R8", {tag, " held shutter"}, int'(shutter_hold), 0);
    endtask

    task automatic run_field(input string tag, input int period,
                             input int new_shut, input int change_line);
        int  lines     = eodd ? VB + ROWS : VB + ROWS + 1;
        int  lim       = (eshut < lines) ? eshut : lines;
        int  exp_drain = (lim - RL - 1 > 0) ? lim - RL - 1 : 0;
        bit  start_odd = eodd;
        int  cnt_err = 0, herr = 0, verr = 0;
        int  n_hd = 0, n_ho = 0, n_he = 0, n_vd = 0, n_vo = 0, n_ve = 0, n_img = 0;
        int  rd_r = 0, rd_t = 0, rd_bad = 0, dr_r = 0, dr_t = 0, dr_bad = 0;
        bit  prev_rd = 1'b0, prev_dr = 1'b0;
        for (int c = 0; c < lines * HT; c++) begin
            bit edum, eob, eeff, vbl, vdm, vob, veff;
            int row;
            if (pix_count != eh || line_count != ev || field_odd != eodd) cnt_err++;
            edum = eh < HD;
            eeff = (eh >= HD + HF) && (eh < HD + HF + HE);
            eob  = !edum && !eeff;
            if ({h_dummy, h_optblack, h_effective} != {edum, eob, eeff}) herr++;
            vbl  = ev < VB;
            vdm  = !eodd && (ev == VB);
            row  = ev - VB - (eodd ? 0 : 1);
            veff = !vbl && !vdm && (row >= VF) && (row < VF + VE);
            vob  = !vbl && !vdm && !veff;
            if ({v_blank, v_dummy, v_optblack, v_effective} != {vbl, vdm, vob, veff}) verr++;
            n_hd += int'(h_dummy);
            n_ho += int'(h_optblack);
            n_he += int'(h_effective);
            n_img += int'(image_valid);
            if (eh == 0) begin
                n_vd += int'(v_dummy);
                n_vo += int'(v_optblack);
                n_ve += int'(v_effective);
            end
            if (readout_pulse && !prev_rd) begin
                rd_r++;
                if (!(ev == RL && eh == 1)) rd_bad++;
            end
            if (drain_pulse && !prev_dr) begin
                dr_r++;
                if (!(ev > RL && ev < eshut && eh == 1)) dr_bad++;
            end
            prev_rd = readout_pulse;
            prev_dr = drain_pulse;
            if (ev == change_line && eh == 0) shutter_line = 4'(new_shut);
            time_tick = ((c % period) == 0);
            if (readout_pulse && time_tick) rd_t++;
            if (drain_pulse && time_tick) dr_t++;
            if (eh == HT - 1 && ev == lines - 1) begin
                eh = 0; ev = 0; eodd = !eodd; eshut = int'(shutter_line);
            end else if (eh == HT - 1) begin
                eh = 0; ev++;
            end else begin
                eh++;
            end
            @(negedge clk);
        end
        chk(cnt_err == 0, "R1", {tag, " counter mismatches"}, cnt_err, 0);
        chk(herr == 0, "R2", {tag, " horizontal flag mismatches"}, herr, 0);
        chk(n_hd == lines * HD, "R2", {tag, " dummy cycles"}, n_hd, lines * HD);
        chk(n_ho == lines * (HF + HR), "R2", {tag, " optical-black cycles"}, n_ho, lines * (HF + HR));
        chk(n_he == lines * HE, "R2", {tag, " effective cycles"}, n_he, lines * HE);
        chk(verr == 0, "R3", {tag, " vertical flag mismatches"}, verr, 0);
        chk(n_vd == (start_odd ? 0 : 1), "R3", {tag, " dummy lines"}, n_vd, start_odd ? 0 : 1);
        chk(n_vo == VF + VR, "R3", {tag, " optical-black lines"}, n_vo, VF + VR);
        chk(n_ve == VE, "R3", {tag, " effective lines"}, n_ve, VE);
        chk(line_count == 0 && field_odd == !start_odd, "R4", {tag, " field restart"},
            int'({line_count, field_odd}), int'({4'd0, !start_odd}));
        chk(n_img == HE * VE, "R5", {tag, " image_valid cycles"}, n_img, HE * VE);
        chk(rd_r == 1 && rd_bad == 0, "R6", {tag, " readout starts"}, rd_r * 10 + rd_bad, 10);
        chk(rd_t == RT, "R6", {tag, " readout ticks"}, rd_t, RT);
        chk(dr_r == exp_drain && dr_bad == 0, "R7", {tag, " drain starts"},
            dr_r * 100 + dr_bad, exp_drain * 100);
        chk(dr_t == exp_drain * DT, "R7", {tag, " drain ticks"}, dr_t, exp_drain * DT);
        chk(int'(shutter_hold) == eshut, "R8", {tag, " shutter captured at field end"},
            int'(shutter_hold), eshut);
    endtask

    task automatic mid_field_reset();
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        time_tick = 1'b0;
        @(negedge clk);
        check_reset_state("mid-field reset");
        rst_n = 1'b1;
        eh = 0; ev = 0; eodd = 1'b1; eshut = 0;
    endtask

    initial begin
        shutter_line = 4'd6;
        repeat (3) @(negedge clk);
        check_reset_state("power-up");
        rst_n = 1'b1;
        run_field("R8 odd field, shutter not yet held", 1, 6, 0);
        run_field("R7 even field, shutter 6, changed to 3 mid-field", 2, 3, 4);
        run_field("R7 odd field, shutter 3 single drain", 3, 2, 5);
        run_field("R7 even field, shutter 2 gives no drain", 1, 15, 3);
        run_field("R7 odd field, shutter past field end", 2, 0, 6);
        mid_field_reset();
        run_field("R9 field after reset", 1, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(40000 * 4);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule